// File: doc/BRIEF.md
# PCM Voice Serial Port (short frame sync, slave)

This block connects a core-clocked datapath to a serial voice or PCM link. An external master supplies the bit clock and a frame-sync pulse that is one bit period wide. The bit clock runs at either 16 or 64 bit periods per frame. The block shifts one transmit stream out on a serial data output and captures one receive stream from a serial data input. The three serial inputs are brought into the core clock domain by a synchronizer. Bit-clock edges are then detected there, so the core clock must run several times faster than the bit clock.

Each frame carries a left word followed by a right word, most significant bit first. A word is either a 16-bit linear sample or an 8-bit companded code. Companded codes pass through the block unchanged and are carried in the low byte of the parallel words. Transmit samples are written through a one-entry valid/ready buffer. Each frame sync moves that buffer into the shifter. Received pairs are presented with a single-cycle valid strobe. Static configuration inputs select the frame length, the word width and which bit-clock edge captures data.

Top module: `pcm_port`

## Requirements
- R1: While reset is asserted and just after it is released, `sdout_o` is 0, `rx_valid` is 0 and `tx_ready` is 1.
- R2: `fsync_i` is sampled on the capture edge of the bit clock. The bit period after the one in which it was sampled high is slot 0 of a new frame. Every word is carried most significant bit first.
- R3: With `cfg_narrow`=1, words are 8 bits wide and only bits [7:0] of `tx_left`/`tx_right` are sent. Received words appear in bits [7:0] of `rx_left`/`rx_right`, and bits [15:8] read 0. At 16 slots per frame, the left code occupies slots 0–7 and the right code occupies slots 8–15.
- R4: With `cfg_hi_rate`=0 and `cfg_narrow`=0, only the left word is carried, in slots 0–15. `tx_right` is not sent, and `rx_right` reads 0.
- R5: With `cfg_hi_rate`=1, a frame has 64 slots. The left word starts at slot 0 and the right word starts at slot 32. `sdin_i` in every other slot has no effect on the received words.
- R6: One core-clock pulse on `rx_valid` follows the capture of the last data bit of a complete frame. The pulse carries both received words, and pairs are delivered in frame order.
- R7: `sdout_o` is 0 in every slot that holds no data bit, and whenever no frame is in progress.
- R8: A sync sampled high before the last data bit of a frame restarts the frame at slot 0. The interrupted frame produces no `rx_valid`.
- R9: `tx_ready` is 1 while the one-entry transmit buffer is empty, and a word is accepted when `tx_valid` and `tx_ready` are both 1. Each frame start moves the buffered pair into the shifter. If the buffer is empty at a frame start, the frame sends zeros.
- R10: With `cfg_cap_fall`=0, data and sync are captured on the rising bit-clock edge and launched on the falling edge. With `cfg_cap_fall`=1, the edges are swapped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, several times the bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_hi_rate | input | 1 | 1: 64 slots per frame, 0: 16 slots |
| cfg_narrow | input | 1 | 1: 8-bit companded words, 0: 16-bit linear |
| cfg_cap_fall | input | 1 | 1: capture on falling edge, 0: capture on rising edge |
| bclk_i | input | 1 | Serial bit clock from the link master |
| fsync_i | input | 1 | Frame sync pulse, one bit period wide |
| sdin_i | input | 1 | Serial receive data |
| sdout_o | output | 1 | Serial transmit data |
| tx_valid | input | 1 | Transmit pair offered |
| tx_ready | output | 1 | Transmit buffer empty |
| tx_left | input | 16 | Transmit left word |
| tx_right | input | 16 | Transmit right word |
| rx_valid | output | 1 | Received pair strobe |
| rx_left | output | 16 | Received left word |
| rx_right | output | 16 | Received right word |

## Verification
At 16 slots per frame, the sync for the next frame falls in the final slot of the current frame. The capture edge that takes in the last data bit and raises `rx_valid` is therefore also the edge that restarts the slot counter and moves the next transmit pair into the shifter. The bench provokes this by running back-to-back 8-bit frames with the sync in slot 15. A scoreboard then checks that both received pairs arrive in order and that the second frame transmits the pair written during the first. The interrupted 64-slot frame checks the other side of the same edge: a restart before the last data bit must produce no pair at all.

// File: rtl/pcm_port_pkg.sv
package pcm_port_pkg;

  typedef struct packed {
    logic hi_rate;   // 64 slots per frame
    logic narrow;    // 8-bit companded words
    logic cap_fall;  // capture on falling bit-clock edge
  } pcm_cfg_t;

  localparam int unsigned PCM_WORD_W   = 16;
  localparam int unsigned PCM_CODE_W   = 8;
  localparam int unsigned PCM_LO_SLOTS = 16;
  localparam int unsigned PCM_HI_SLOTS = 64;

endpackage

// File: rtl/pcm_pin_sync.sv
module pcm_pin_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cap_fall,
  input  logic bclk_i,
  input  logic fsync_i,
  input  logic sdin_i,
  output logic cap_stb,
  output logic lau_stb,
  output logic sync_s,
  output logic sdin_s
);

  logic [2:0] pipe_q [STAGES];
  logic       bclk_prev_q;
  logic       bclk_s;
  logic       rise;
  logic       fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) pipe_q[i] <= 3'b000;
      bclk_prev_q <= 1'b0;
    end else begin
      pipe_q[0] <= {bclk_i, fsync_i, sdin_i};
      for (int i = 1; i < STAGES; i++) pipe_q[i] <= pipe_q[i-1];
      bclk_prev_q <= bclk_s;
    end
  end

  always_comb begin
    bclk_s  = pipe_q[STAGES-1][2];
    sync_s  = pipe_q[STAGES-1][1];
    sdin_s  = pipe_q[STAGES-1][0];
    rise    = bclk_s & ~bclk_prev_q;
    fall    = ~bclk_s & bclk_prev_q;
    cap_stb = cap_fall ? fall : rise;
    lau_stb = cap_fall ? rise : fall;
  end

  a_r10_edges_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(cap_stb && lau_stb));

endmodule

// File: rtl/pcm_slot_ctrl.sv
module pcm_slot_ctrl #(
  parameter int unsigned WORD_W   = 16,
  parameter int unsigned CODE_W   = 8,
  parameter int unsigned LO_SLOTS = 16,
  parameter int unsigned HI_SLOTS = 64
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cap_stb,
  input  logic                        sync_s,
  input  logic                        hi_rate,
  input  logic                        narrow,
  output logic                        frame_start,
  output logic                        slot_left,
  output logic                        slot_right,
  output logic                        slot_last,
  output logic [$clog2(WORD_W)-1:0]   slot_idx
);

  localparam int unsigned SLOT_W = $clog2(HI_SLOTS);
  localparam int unsigned IDX_W  = $clog2(WORD_W);
  localparam logic [SLOT_W-1:0] WIDE_LEN = SLOT_W'(WORD_W);
  localparam logic [SLOT_W-1:0] CODE_LEN = SLOT_W'(CODE_W);
  localparam logic [SLOT_W-1:0] HI_HALF  = SLOT_W'(HI_SLOTS / 2);
  localparam logic [SLOT_W-1:0] LO_END   = SLOT_W'(LO_SLOTS - 1);
  localparam logic [SLOT_W-1:0] HI_END   = SLOT_W'(HI_SLOTS - 1);

  logic              active_q, active_d;
  logic [SLOT_W-1:0] pos_q, pos_d;
  logic [SLOT_W-1:0] wlen, rstart, rel, idx_full, last_pos, wrap_pos;
  logic              in_left, in_right;

  always_comb begin
    wlen     = narrow ? CODE_LEN : WIDE_LEN;
    rstart   = hi_rate ? HI_HALF : wlen;
    rel      = pos_q - rstart;
    in_left  = pos_q < wlen;
    in_right = (hi_rate | narrow) && (pos_q >= rstart) && (rel < wlen);
    idx_full = wlen - 1'b1 - (in_left ? pos_q : rel);
    last_pos = hi_rate ? (rstart + wlen - 1'b1) : LO_END;
    wrap_pos = hi_rate ? HI_END : LO_END;

    slot_left   = active_q & in_left;
    slot_right  = active_q & in_right;
    slot_last   = active_q & (pos_q == last_pos);
    slot_idx    = idx_full[IDX_W-1:0];
    frame_start = cap_stb & sync_s;
  end

  always_comb begin
    active_d = active_q;
    pos_d    = pos_q;
    if (cap_stb) begin
      if (sync_s) begin
        active_d = 1'b1;
        pos_d    = '0;
      end else if (active_q) begin
        if (pos_q == wrap_pos) active_d = 1'b0;
        else                   pos_d    = pos_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      pos_q    <= '0;
    end else begin
      active_q <= active_d;
      pos_q    <= pos_d;
    end
  end

  a_r8_sync_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_stb && sync_s) |=> (active_q && pos_q == '0));

  a_r2_lo_frame_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && !hi_rate) |-> (pos_q <= LO_END));

  a_r2_count_steps: assert property (@(posedge clk) disable iff (!rst_n)
    (!cap_stb) |=> $stable(pos_q));

endmodule

// File: rtl/pcm_tx_path.sv
module pcm_tx_path #(
  parameter int unsigned WORD_W = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      tx_valid,
  input  logic [WORD_W-1:0]         tx_left,
  input  logic [WORD_W-1:0]         tx_right,
  output logic                      tx_ready,
  input  logic                      frame_start,
  input  logic                      lau_stb,
  input  logic                      slot_left,
  input  logic                      slot_right,
  input  logic [$clog2(WORD_W)-1:0] slot_idx,
  output logic                      sdout
);

  logic              full_q, full_d;
  logic [WORD_W-1:0] buf_l_q, buf_r_q, cur_l_q, cur_r_q;
  logic              accept, bit_d;

  always_comb begin
    accept   = tx_valid & ~full_q;
    tx_ready = ~full_q;
    full_d   = full_q;
    if (frame_start) full_d = 1'b0;
    if (accept)      full_d = 1'b1;
    bit_d = 1'b0;
    if (slot_left)       bit_d = cur_l_q[slot_idx];
    else if (slot_right) bit_d = cur_r_q[slot_idx];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q  <= 1'b0;
      buf_l_q <= '0;
      buf_r_q <= '0;
      cur_l_q <= '0;
      cur_r_q <= '0;
      sdout   <= 1'b0;
    end else begin
      full_q <= full_d;
      if (accept) begin
        buf_l_q <= tx_left;
        buf_r_q <= tx_right;
      end
      if (frame_start) begin
        cur_l_q <= full_q ? buf_l_q : '0;
        cur_r_q <= full_q ? buf_r_q : '0;
      end
      if (lau_stb) sdout <= bit_d;
    end
  end

  a_r9_accept_fills: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> !tx_ready);

  a_r7_unused_slot_low: assert property (@(posedge clk) disable iff (!rst_n)
    (lau_stb && !slot_left && !slot_right) |=> !sdout);

endmodule

// File: rtl/pcm_rx_path.sv
module pcm_rx_path #(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned CODE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_stb,
  input  logic              sdin_s,
  input  logic              narrow,
  input  logic              has_right,
  input  logic              slot_left,
  input  logic              slot_right,
  input  logic              slot_last,
  output logic              rx_valid,
  output logic [WORD_W-1:0] rx_left,
  output logic [WORD_W-1:0] rx_right
);

  logic [WORD_W-1:0] sh_l_q, sh_r_q, sh_l_d, sh_r_d, out_l, out_r;

  always_comb begin
    sh_l_d = slot_left  ? {sh_l_q[WORD_W-2:0], sdin_s} : sh_l_q;
    sh_r_d = slot_right ? {sh_r_q[WORD_W-2:0], sdin_s} : sh_r_q;
    out_l  = narrow ? {{(WORD_W-CODE_W){1'b0}}, sh_l_d[CODE_W-1:0]} : sh_l_d;
    out_r  = narrow ? {{(WORD_W-CODE_W){1'b0}}, sh_r_d[CODE_W-1:0]} : sh_r_d;
    if (!has_right) out_r = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_l_q   <= '0;
      sh_r_q   <= '0;
      rx_valid <= 1'b0;
      rx_left  <= '0;
      rx_right <= '0;
    end else begin
      rx_valid <= 1'b0;
      if (cap_stb) begin
        sh_l_q <= sh_l_d;
        sh_r_q <= sh_r_d;
        if (slot_last) begin
          rx_valid <= 1'b1;
          rx_left  <= out_l;
          rx_right <= out_r;
        end
      end
    end
  end

  a_r6_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  a_r6_valid_from_capture: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_valid) |-> $past(cap_stb));

endmodule

// File: rtl/pcm_port.sv
module pcm_port
  import pcm_port_pkg::*;
#(
  parameter int unsigned WORD_W      = PCM_WORD_W,
  parameter int unsigned CODE_W      = PCM_CODE_W,
  parameter int unsigned LO_SLOTS    = PCM_LO_SLOTS,
  parameter int unsigned HI_SLOTS    = PCM_HI_SLOTS,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_hi_rate,
  input  logic              cfg_narrow,
  input  logic              cfg_cap_fall,
  input  logic              bclk_i,
  input  logic              fsync_i,
  input  logic              sdin_i,
  output logic              sdout_o,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [WORD_W-1:0] tx_left,
  input  logic [WORD_W-1:0] tx_right,
  output logic              rx_valid,
  output logic [WORD_W-1:0] rx_left,
  output logic [WORD_W-1:0] rx_right
);

  localparam int unsigned IDX_W = $clog2(WORD_W);

  pcm_cfg_t   cfg;
  logic [1:0] rst_pipe_q;
  logic       rst_int_n;
  logic       cap_stb, lau_stb, sync_s, sdin_s;
  logic       frame_start, slot_left, slot_right, slot_last;
  logic [IDX_W-1:0] slot_idx;

  always_comb cfg = '{hi_rate: cfg_hi_rate, narrow: cfg_narrow, cap_fall: cfg_cap_fall};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  pcm_pin_sync #(.STAGES(SYNC_STAGES)) u_pins (
    .clk(clk), .rst_n(rst_int_n), .cap_fall(cfg.cap_fall),
    .bclk_i(bclk_i), .fsync_i(fsync_i), .sdin_i(sdin_i),
    .cap_stb(cap_stb), .lau_stb(lau_stb), .sync_s(sync_s), .sdin_s(sdin_s)
  );

  pcm_slot_ctrl #(.WORD_W(WORD_W), .CODE_W(CODE_W),
                  .LO_SLOTS(LO_SLOTS), .HI_SLOTS(HI_SLOTS)) u_slots (
    .clk(clk), .rst_n(rst_int_n), .cap_stb(cap_stb), .sync_s(sync_s),
    .hi_rate(cfg.hi_rate), .narrow(cfg.narrow), .frame_start(frame_start),
    .slot_left(slot_left), .slot_right(slot_right), .slot_last(slot_last),
    .slot_idx(slot_idx)
  );

  pcm_tx_path #(.WORD_W(WORD_W)) u_tx (
    .clk(clk), .rst_n(rst_int_n), .tx_valid(tx_valid), .tx_left(tx_left),
    .tx_right(tx_right), .tx_ready(tx_ready), .frame_start(frame_start),
    .lau_stb(lau_stb), .slot_left(slot_left), .slot_right(slot_right),
    .slot_idx(slot_idx), .sdout(sdout_o)
  );

  pcm_rx_path #(.WORD_W(WORD_W), .CODE_W(CODE_W)) u_rx (
    .clk(clk), .rst_n(rst_int_n), .cap_stb(cap_stb), .sdin_s(sdin_s),
    .narrow(cfg.narrow), .has_right(cfg.hi_rate | cfg.narrow),
    .slot_left(slot_left), .slot_right(slot_right), .slot_last(slot_last),
    .rx_valid(rx_valid), .rx_left(rx_left), .rx_right(rx_right)
  );

  a_r4_no_right_in_lo_wide: assert property (@(posedge clk) disable iff (!rst_int_n)
    (rx_valid && !cfg_hi_rate && !cfg_narrow) |-> (rx_right == '0));

  a_r3_code_upper_zero: assert property (@(posedge clk) disable iff (!rst_int_n)
    (rx_valid && cfg_narrow) |-> (rx_left[WORD_W-1:CODE_W] == '0 && rx_right[WORD_W-1:CODE_W] == '0));

endmodule

// File: tb/pcm_port_test.sv
module pcm_port_test;

  localparam int HALF = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_hi_rate = 1'b0, cfg_narrow = 1'b0, cfg_cap_fall = 1'b0;
  logic        bclk_i = 1'b1, fsync_i = 1'b0, sdin_i = 1'b0;
  logic        sdout_o, tx_ready, rx_valid;
  logic        tx_valid = 1'b0;
  logic [15:0] tx_left = '0, tx_right = '0, rx_left, rx_right;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [31:0] exp_q [$];

  always #4 clk = ~clk;

  pcm_port uut (
    .clk(clk), .rst_n(rst_n), .cfg_hi_rate(cfg_hi_rate), .cfg_narrow(cfg_narrow),
    .cfg_cap_fall(cfg_cap_fall), .bclk_i(bclk_i), .fsync_i(fsync_i), .sdin_i(sdin_i),
    .sdout_o(sdout_o), .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_left(tx_left),
    .tx_right(tx_right), .rx_valid(rx_valid), .rx_left(rx_left), .rx_right(rx_right)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // R6: monitor pops the scoreboard on every received pair
  always @(negedge clk) begin
    if (rst_n && rx_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R6/R8 unexpected pair", {32'h0, rx_left, rx_right}, 64'h0);
      end else begin
        logic [31:0] e;
        e = exp_q.pop_front();
        check({rx_left, rx_right} == e, "R6 received pair", {32'h0, rx_left, rx_right}, {32'h0, e});
      end
    end
  end

  // expected serial bit in slot s, or dflt if the slot carries no data
  function automatic logic slot_bit(input int s, input logic [15:0] a, input logic [15:0] b, input logic dflt);
    int w;
    int rs;
    w  = cfg_narrow ? 8 : 16;
    rs = cfg_hi_rate ? 32 : w;
    if (s < w) return a[w-1-s];
    if ((cfg_hi_rate || cfg_narrow) && s >= rs && s < rs + w) return b[w-1-(s-rs)];
    return dflt;
  endfunction

  task automatic bit_period(input logic sy, input logic d, output logic txb);
    @(negedge clk);
    bclk_i  = cfg_cap_fall;   // launch edge
    fsync_i = sy;
    sdin_i  = d;
    repeat (HALF) @(negedge clk);
    txb = sdout_o;
    bclk_i = ~cfg_cap_fall;   // capture edge
    repeat (HALF) @(negedge clk);
  endtask

  task automatic idle(input int n);
    logic t;
    for (int i = 0; i < n; i++) bit_period(1'b0, 1'b0, t);
  endtask

  task automatic sync_only();
    logic t;
    bit_period(1'b1, 1'b0, t);
  endtask

  task automatic tx_push(input logic [15:0] l, input logic [15:0] r);
    @(negedge clk);
    while (!tx_ready) @(negedge clk);
    tx_valid = 1'b1; tx_left = l; tx_right = r;
    @(negedge clk);
    tx_valid = 1'b0;
    check(!tx_ready, "R9 ready drops after accept", {63'h0, tx_ready}, 64'h0);
  endtask

  task automatic frame(input logic [15:0] rl, input logic [15:0] rr,
                       input logic [15:0] tl, input logic [15:0] tr,
                       input int nslots, input bit sync_last, input string tag);
    int flen;
    logic [63:0] got, exp_bits;
    flen = cfg_hi_rate ? 64 : 16;
    got = '0; exp_bits = '0;
    if (nslots == flen) begin
      logic [15:0] el, er;
      el = cfg_narrow ? {8'h00, rl[7:0]} : rl;
      er = (cfg_hi_rate || cfg_narrow) ? (cfg_narrow ? {8'h00, rr[7:0]} : rr) : 16'h0;
      exp_q.push_back({el, er});
    end
    for (int s = 0; s < nslots; s++) begin
      logic t;
      bit_period(sync_last && (s == nslots - 1), slot_bit(s, rl, rr, 1'b1), t);
      got[s] = t;
      exp_bits[s] = slot_bit(s, tl, tr, 1'b0);
    end
    check(got == exp_bits, tag, got, exp_bits);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    // R1: reset state
    check(sdout_o == 1'b0, "R1 sdout in reset", {63'h0, sdout_o}, 64'h0);
    check(rx_valid == 1'b0, "R1 rx_valid in reset", {63'h0, rx_valid}, 64'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(tx_ready == 1'b1, "R1 tx_ready after reset", {63'h0, tx_ready}, 64'h1);
    check(sdout_o == 1'b0, "R1 sdout after reset", {63'h0, sdout_o}, 64'h0);

    // R3 / R2: 8-bit codes at 16 slots, back-to-back frames, sync in slot 15
    cfg_hi_rate = 0; cfg_narrow = 1; cfg_cap_fall = 0;
    idle(2);
    tx_push(16'h12A5, 16'hFF3C);
    sync_only();
    tx_push(16'h0081, 16'h007E);
    frame(16'h005A, 16'h00C3, 16'h12A5, 16'hFF3C, 16, 1'b1, "R3 tx bits frame 1");
    frame(16'hAB81, 16'h667E, 16'h0081, 16'h007E, 16, 1'b0, "R3/R9 tx bits frame 2");
    idle(2);

    // R4 / R10: 16-bit linear at 16 slots, capture on falling edge
    cfg_narrow = 0; cfg_cap_fall = 1;
    idle(2);
    tx_push(16'hBEEF, 16'h1234);
    sync_only();
    frame(16'hCAFE, 16'h5555, 16'hBEEF, 16'h1234, 16, 1'b0, "R4/R10 tx bits");
    idle(2);

    // R5 / R7 / R2: 64 slots, 16-bit, unused receive slots driven high
    cfg_hi_rate = 1; cfg_cap_fall = 0;
    idle(2);
    tx_push(16'h8001, 16'hC3A5);
    sync_only();
    frame(16'h7E18, 16'h9C01, 16'h8001, 16'hC3A5, 64, 1'b0, "R5/R7 tx bits");
    idle(2);

    // R9 underrun, 64 slots 8-bit, falling capture
    cfg_narrow = 1; cfg_cap_fall = 1;
    idle(2);
    sync_only();
    frame(16'h00E7, 16'h0042, 16'h0000, 16'h0000, 64, 1'b0, "R9 underrun zeros");
    idle(2);

    // R8: restart in the middle of the left word
    cfg_narrow = 0; cfg_cap_fall = 0;
    idle(2);
    tx_push(16'hA0A0, 16'h0505);
    sync_only();
    tx_push(16'h3C3C, 16'hF00F);
    frame(16'hFFFF, 16'hFFFF, 16'hA0A0, 16'h0505, 10, 1'b1, "R8 partial tx bits");
    frame(16'h1357, 16'h2468, 16'h3C3C, 16'hF00F, 64, 1'b0, "R8 restarted frame");
    idle(3);

    check(sdout_o == 1'b0, "R7 idle line low", {63'h0, sdout_o}, 64'h0);
    check(exp_q.size() == 0, "R6 all pairs delivered", 64'(exp_q.size()), 64'h0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule